// File: doc/BRIEF.md
# Watchdog Reset Retry Limiter

This block sits between a management controller's watchdog logic and the reset lines of that controller. Each time the watchdog decides that a recovery is needed, it presents a request marked as either a processor hardware reset or a restart of the whole firmware stack. The limiter turns each request into a fixed-length pulse on the reset line for that kind. Both kinds count against one shared budget. After the budget of attempts has been spent, the block stops issuing resets and raises a flag that keeps the controller parked in its bootloader.

The budget is restored in two ways. A power-on reset restores it at once. It is also restored when the controller has run without any watchdog reset for strictly longer than a quiet period, which is measured in seconds. A prescaler derives a one-second tick from the clock frequency parameter. The quiet timer restarts on every reset the block issues. While a pulse is active, any further request is folded into it and does not count.

Top module: `wdt_retry_limiter`

## Requirements
- R1: When no pulse is active and the block has not given up, a request with `req_kind` 0 drives `cpu_rst_pulse` high, and `req_kind` 1 drives `fw_rst_pulse` high. The pulse rises on the clock edge that samples the request and stays high for exactly PULSE_CYCLES cycles.
- R2: Each accepted request adds one to `attempt_cnt` on the same edge that starts its pulse. Both kinds add to the same count.
- R3: A request that arrives while either pulse is high is dropped. This includes the last cycle of a pulse. A dropped request starts no pulse and leaves `attempt_cnt` unchanged.
- R4: `stay_in_boot` rises on the edge where `attempt_cnt` reaches MAX_TRIES (3 by default). While it is high, requests produce no pulse and the count does not change.
- R5: While `por` is high at a clock edge, the count, `stay_in_boot` and both pulses are cleared, and any request on that edge is ignored.
- R6: When (QUIET_SEC+1)*CLK_HZ clock edges have passed since the last accepted request, `attempt_cnt` and `stay_in_boot` both return to 0 on that edge. This is strictly more than QUIET_SEC seconds.
- R7: Every accepted request restarts the quiet-period measurement from zero.
- R8: `cpu_rst_pulse` and `fw_rst_pulse` are never high at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at CLK_HZ |
| por | input | 1 | Synchronous active-high power-on reset |
| req_valid | input | 1 | Watchdog recovery request, one cycle per request |
| req_kind | input | 1 | 0 = processor hardware reset, 1 = firmware stack reset |
| cpu_rst_pulse | output | 1 | Processor hardware reset pulse |
| fw_rst_pulse | output | 1 | Firmware stack reset pulse |
| stay_in_boot | output | 1 | Retry budget spent; remain in bootloader |
| attempt_cnt | output | $clog2(MAX_TRIES+1) | Recovery resets issued since the last clear |

## Verification
The main function is exercised with three patterns:
- Alternating request kinds separated by idle gaps. This shows that both kinds share one count and that each kind routes to its own output.
- Requests placed inside a pulse and on its final cycle. This tells merging apart from double counting.
- Requests after the budget is spent. This shows that the give-up state blocks pulses.

The quiet-period check samples one edge before and one edge on the clearing point. A second request placed mid-period shows that the timer restarts rather than running on from the first request. Power-on reset is applied both mid-pulse and after give-up, with a request on the same edge.

// File: rtl/wrl_pkg.sv
package wrl_pkg;
  typedef enum logic {
    KIND_CPU = 1'b0,
    KIND_FW  = 1'b1
  } rst_kind_e;
endpackage

// File: rtl/wrl_sec_tick.sv
module wrl_sec_tick #(
  parameter int CLK_HZ = 125_000_000
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  output logic tick
);
  localparam int PW = (CLK_HZ > 1) ? $clog2(CLK_HZ) : 1;

  logic [PW-1:0] div_q;

  assign tick = (div_q == PW'(CLK_HZ - 1));

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      div_q <= '0;
    end else if (tick) begin
      div_q <= '0;
    end else begin
      div_q <= div_q + 1'b1;
    end
  end
endmodule

// File: rtl/wrl_quiet_timer.sv
module wrl_quiet_timer #(
  parameter int QUIET_SEC = 1800
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic enable,
  input  logic tick,
  output logic expire
);
  localparam int SW = $clog2(QUIET_SEC + 1);

  logic [SW-1:0] sec_q;

  // fires on the tick that would move the count past QUIET_SEC
  assign expire = enable && tick && (sec_q == SW'(QUIET_SEC));

  always_ff @(posedge clk) begin
    if (rst || restart || !enable) begin
      sec_q <= '0;
    end else if (tick && !expire) begin
      sec_q <= sec_q + 1'b1;
    end
  end
endmodule

// File: rtl/wrl_pulse_gen.sv
module wrl_pulse_gen
  import wrl_pkg::*;
#(
  parameter int PULSE_CYCLES = 16
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      start,
  input  rst_kind_e kind,
  output logic      busy,
  output logic      cpu_o,
  output logic      fw_o
);
  localparam int LW = (PULSE_CYCLES > 1) ? $clog2(PULSE_CYCLES) : 1;

  logic [LW-1:0] left_q;
  logic          cpu_q, fw_q;

  assign busy  = cpu_q | fw_q;
  assign cpu_o = cpu_q;
  assign fw_o  = fw_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_q  <= 1'b0;
      fw_q   <= 1'b0;
      left_q <= '0;
    end else if (start) begin
      cpu_q  <= (kind == KIND_CPU);
      fw_q   <= (kind == KIND_FW);
      left_q <= LW'(PULSE_CYCLES - 1);
    end else if (busy) begin
      if (left_q == '0) begin
        cpu_q <= 1'b0;
        fw_q  <= 1'b0;
      end else begin
        left_q <= left_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/wdt_retry_limiter.sv
module wdt_retry_limiter
  import wrl_pkg::*;
#(
  parameter int CLK_HZ       = 125_000_000,
  parameter int QUIET_SEC    = 1800,
  parameter int PULSE_CYCLES = 16,
  parameter int MAX_TRIES    = 3,
  localparam int CW          = $clog2(MAX_TRIES + 1)
) (
  input  logic          clk,
  input  logic          por,
  input  logic          req_valid,
  input  logic          req_kind,
  output logic          cpu_rst_pulse,
  output logic          fw_rst_pulse,
  output logic          stay_in_boot,
  output logic [CW-1:0] attempt_cnt
);
  logic          busy, accept, tick, expire;
  logic [CW-1:0] cnt_q;
  logic          boot_q;

  assign accept = req_valid && !busy && !boot_q;

  wrl_sec_tick #(.CLK_HZ(CLK_HZ)) u_tick (
    .clk     (clk),
    .rst     (por),
    .restart (accept),
    .tick    (tick)
  );

  wrl_quiet_timer #(.QUIET_SEC(QUIET_SEC)) u_quiet (
    .clk     (clk),
    .rst     (por),
    .restart (accept),
    .enable  (cnt_q != '0),
    .tick    (tick),
    .expire  (expire)
  );

  wrl_pulse_gen #(.PULSE_CYCLES(PULSE_CYCLES)) u_pulse (
    .clk   (clk),
    .rst   (por),
    .start (accept),
    .kind  (rst_kind_e'(req_kind)),
    .busy  (busy),
    .cpu_o (cpu_rst_pulse),
    .fw_o  (fw_rst_pulse)
  );

  always_ff @(posedge clk) begin
    if (por) begin
      cnt_q  <= '0;
      boot_q <= 1'b0;
    end else if (accept) begin
      cnt_q  <= cnt_q + 1'b1;
      boot_q <= (cnt_q + 1'b1 == CW'(MAX_TRIES));
    end else if (expire) begin
      cnt_q  <= '0;
      boot_q <= 1'b0;
    end
  end

  assign stay_in_boot = boot_q;
  assign attempt_cnt  = cnt_q;
endmodule

// File: rtl/wrl_checker.sv
module wrl_checker #(
  parameter int PULSE_CYCLES = 16,
  parameter int MAX_TRIES    = 3,
  parameter int CW           = 2
) (
  input logic          clk,
  input logic          por,
  input logic          cpu_rst_pulse,
  input logic          fw_rst_pulse,
  input logic          stay_in_boot,
  input logic [CW-1:0] attempt_cnt
);
  localparam int RW = $clog2(PULSE_CYCLES + 2);

  logic          any_hi;
  logic [RW-1:0] run_q;

  assign any_hi = cpu_rst_pulse | fw_rst_pulse;

  always_ff @(posedge clk) begin
    if (por || !any_hi) run_q <= '0;
    else                run_q <= run_q + 1'b1;
  end

  a_r8_exclusive: assert property (@(posedge clk) disable iff (por)
    !(cpu_rst_pulse && fw_rst_pulse));

  a_r1_pulse_not_long: assert property (@(posedge clk) disable iff (por)
    any_hi |-> (run_q < RW'(PULSE_CYCLES)));

  a_r1_pulse_full_len: assert property (@(posedge clk) disable iff (por)
    ($fell(any_hi) && !$past(por)) |-> ($past(run_q) == RW'(PULSE_CYCLES - 1)));

  a_r2_step_on_pulse: assert property (@(posedge clk) disable iff (por)
    ($rose(any_hi) && !$past(por)) |-> (attempt_cnt == $past(attempt_cnt) + 1'b1));

  a_r3_change_only_on_rise: assert property (@(posedge clk) disable iff (por)
    ((attempt_cnt != $past(attempt_cnt)) && (attempt_cnt != '0) && !$past(por))
      |-> $rose(any_hi));

  a_r4_flag_at_limit: assert property (@(posedge clk) disable iff (por)
    stay_in_boot |-> (attempt_cnt == CW'(MAX_TRIES)));

  a_r4_hold_when_gave_up: assert property (@(posedge clk) disable iff (por)
    stay_in_boot |=> (!$rose(any_hi)));
endmodule

bind wdt_retry_limiter wrl_checker #(
  .PULSE_CYCLES (PULSE_CYCLES),
  .MAX_TRIES    (MAX_TRIES),
  .CW           (CW)
) u_chk (
  .clk           (clk),
  .por           (por),
  .cpu_rst_pulse (cpu_rst_pulse),
  .fw_rst_pulse  (fw_rst_pulse),
  .stay_in_boot  (stay_in_boot),
  .attempt_cnt   (attempt_cnt)
);

// File: tb/wdt_retry_limiter_bench.sv
`timescale 1ns/1ps
module wdt_retry_limiter_bench;
  localparam int CLK_HZ = 4;
  localparam int QSEC   = 3;
  localparam int PULSE  = 3;
  localparam int TRIES  = 3;

  logic       clk = 1'b0;
  logic       por = 1'b1;
  logic       req_valid = 1'b0;
  logic       req_kind = 1'b0;
  logic       cpu_rst_pulse, fw_rst_pulse, stay_in_boot;
  logic [1:0] attempt_cnt;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  wdt_retry_limiter #(
    .CLK_HZ(CLK_HZ), .QUIET_SEC(QSEC), .PULSE_CYCLES(PULSE), .MAX_TRIES(TRIES)
  ) u_wdt_retry_limiter (
    .clk(clk), .por(por), .req_valid(req_valid), .req_kind(req_kind),
    .cpu_rst_pulse(cpu_rst_pulse), .fw_rst_pulse(fw_rst_pulse),
    .stay_in_boot(stay_in_boot), .attempt_cnt(attempt_cnt)
  );

  // {valid, kind, exp_cpu, exp_fw, exp_cnt[1:0], exp_boot}
  localparam logic [6:0] VEC [14] = '{
    7'b1010010, 7'b1110010, 7'b0010010, 7'b1100010,
    7'b1101100, 7'b0001100, 7'b0001100, 7'b0000100,
    7'b1010111, 7'b0010111, 7'b0010111, 7'b0000111,
    7'b1100111, 7'b1000111
  };

  task automatic chk(input string tag, input logic [4:0] exp);
    logic [4:0] act;
    act = {cpu_rst_pulse, fw_rst_pulse, attempt_cnt, stay_in_boot};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got cpu/fw/cnt/boot=%b expected %b", tag, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic k);
    @(negedge clk);
    req_valid = v;
    req_kind  = k;
    @(posedge clk);
    #1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: run did not finish, got hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    #1;
    chk("R5 reset state", 5'b00000);
    @(negedge clk) por = 1'b0;

    // R1/R2/R3/R4/R8 table walk
    for (int i = 0; i < 14; i++) begin
      step(VEC[i][6], VEC[i][5]);
      chk($sformatf("R1/R2/R3/R4/R8 table step %0d", i), VEC[i][4:0]);
    end

    // last accepted request was at step 8; 5 edges have passed
    idle(10);
    chk("R6 still given up one edge before clear", 5'b00111);
    idle(1);
    chk("R6 quiet period clears count and flag", 5'b00000);
    step(1'b1, 1'b1);
    chk("R6 retries allowed after release", 5'b01010);

    idle(9);
    step(1'b1, 1'b0);
    chk("R7 second request mid-period", 5'b10100);
    idle(15);
    chk("R7 timer restarted, count kept", 5'b00100);
    idle(1);
    chk("R6 clear after restarted period", 5'b00000);

    step(1'b1, 1'b0);
    chk("R1 pulse before por", 5'b10010);
    @(negedge clk);
    por = 1'b1; req_valid = 1'b1; req_kind = 1'b1;
    @(posedge clk); #1;
    chk("R5 por mid-pulse with request", 5'b00000);
    @(negedge clk) por = 1'b0;

    step(1'b1, 1'b0); idle(4);
    step(1'b1, 1'b1); idle(4);
    step(1'b1, 1'b0);
    chk("R4 limit reached again", 5'b10111);
    @(negedge clk);
    por = 1'b1; req_valid = 1'b0;
    @(posedge clk); #1;
    chk("R5 por releases give-up", 5'b00000);
    @(negedge clk) por = 1'b0;
    step(1'b1, 1'b1);
    chk("R5 request accepted after por", 5'b01010);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule